// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Burst Fill

This block is a direct-mapped cache for 32-bit data words. It holds 256 lines, and each line has 8 words. It supports three operations.

- **Lookup:** compares the stored tag and the valid bit of the indexed line. One cycle later it returns the selected word and a registered miss flag, both in the same cycle.
- **Single-word store:** changes one word of a line that already holds the address.
- **Line fill:** writes a whole line from an outer memory interface, one word per clock, while burst enable is held high.

The block raises miss and does nothing more. Its user must stall until a later lookup reports a hit. When several enables are high in the same cycle, burst takes priority over store, and store takes priority over lookup.

Top module: `lineCache`

## Requirements
- R1: The address is divided as follows: bits [2:0] select the word within a line, bits [10:3] select one of 256 lines, and bits [23:11] are the tag. Two addresses with the same index but different tags share one line.
- R2: When readEn is high and burstEn and wrEn are low, dataOut and miss are loaded on that clock edge. Both are visible in the following cycle. In every other cycle, dataOut and miss keep their values.
- R3: Reset drives miss to 1 and dataOut to 0, and it invalidates every line. The first lookup of any address after reset reports miss = 1.
- R4: During a fill, the n-th consecutive cycle with burstEn high writes dataIn into word n (counted from 0) of the line indexed by addr. The word bits of addr are ignored during a fill, and the line takes the tag of addr.
- R5: A line becomes valid only on the eighth fill word. A fill that stops before its eighth word leaves the line invalid, so lookups to that line report miss = 1, whatever tag the line held before.
- R6: The fill word counter returns to word 0 whenever burstEn is low for a cycle. If burstEn stays high beyond 8 cycles, the counter wraps to word 0, so back-to-back fills each start at word 0.
- R7: A store (wrEn high, burstEn low) writes dataIn to the addressed word only when the line is valid and its tag matches. Otherwise the store changes no data and no valid state.
- R8: If burstEn is high, the fill word is the only action in that cycle. If wrEn is high and burstEn is low, the lookup outputs hold.
- R9: When miss = 0, dataOut equals the most recent value written to that address by a fill or a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Word address: tag, line index and word offset |
| dataIn | input | 32 | Write data for fills and stores |
| readEn | input | 1 | Lookup request |
| wrEn | input | 1 | Single-word store request |
| burstEn | input | 1 | Line fill, held high for one word per cycle |
| dataOut | output | 32 | Registered lookup data |
| miss | output | 1 | Registered miss flag, aligned with dataOut |

## Verification
There are two likely kinds of internal fault.

- **Fill counter fault:** the counter may fail to restart, or it may step wrongly. Either fault puts words in the wrong slots. It shows up on the very next lookup of that line as wrong data with miss = 0.
- **Valid-bit fault:** a valid bit may be set too early, or a store may be accepted on a wrong-tag or invalid line. Either fault shows up within one cycle as a lookup that reports a hit when it should report a miss, or returns stale data.

To catch both, the bench fills all 256 lines and reads back every word. It also reads each line straight after a partial fill, and it checks aliasing, priority and output hold cycle by cycle.

// File: rtl/lineCachePkg.sv
`timescale 1ns/1ps
package lineCachePkg;
  typedef struct packed {
    logic fillWord;
    logic storeWord;
    logic loadOut;
    logic dropValid;
    logic markValid;
  } cacheStrobeT;
endpackage

// File: rtl/lineCacheCtrl.sv
`timescale 1ns/1ps
module lineCacheCtrl
  import lineCachePkg::*;
#(
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burstEn,
  input  logic             wrEn,
  input  logic             readEn,
  input  logic             lookupHit,
  output cacheStrobeT      strobe,
  output logic [OFF_W-1:0] wordSel
);
  localparam logic [OFF_W-1:0] LAST_WORD = '1;

  logic [OFF_W-1:0] fillCnt;

  // Counter runs while burst is held, wraps after the last word, restarts on any gap.
  always_ff @(posedge clk) begin
    if (rst)          fillCnt <= '0;
    else if (burstEn) fillCnt <= fillCnt + 1'b1;
    else              fillCnt <= '0;
  end

  assign wordSel = fillCnt;

  always_comb begin
    strobe = '0;
    if (burstEn) begin
      strobe.fillWord  = 1'b1;
      strobe.dropValid = (fillCnt == '0);
      strobe.markValid = (fillCnt == LAST_WORD);
    end else if (wrEn) begin
      strobe.storeWord = lookupHit;
    end else if (readEn) begin
      strobe.loadOut = 1'b1;
    end
  end
endmodule

// File: rtl/lineCacheData.sv
`timescale 1ns/1ps
module lineCacheData
  import lineCachePkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  cacheStrobeT       strobe,
  input  logic [OFF_W-1:0]  wordSel,
  output logic              lookupHit,
  output logic [DATA_W-1:0] dataOut,
  output logic              miss
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = LINES << OFF_W;
  localparam int PTR_W = IDX_W + OFF_W;

  logic [DATA_W-1:0] wordStore [WORDS];
  logic [TAG_W-1:0]  tagStore  [LINES];
  logic [LINES-1:0]  lineValid;

  logic [OFF_W-1:0] offF;
  logic [IDX_W-1:0] idxF;
  logic [TAG_W-1:0] tagF;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;

  assign offF  = addr[OFF_W-1:0];
  assign idxF  = addr[OFF_W +: IDX_W];
  assign tagF  = addr[ADDR_W-1 -: TAG_W];
  assign rdPtr = {idxF, offF};
  assign wrPtr = strobe.fillWord ? {idxF, wordSel} : rdPtr;

  assign lookupHit = lineValid[idxF] && (tagStore[idxF] == tagF);

  always_ff @(posedge clk) begin
    if (strobe.fillWord || strobe.storeWord) wordStore[wrPtr] <= dataIn;
    if (strobe.fillWord)                     tagStore[idxF]  <= tagF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineValid <= '0;
    end else begin
      if (strobe.dropValid) lineValid[idxF] <= 1'b0;
      if (strobe.markValid) lineValid[idxF] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
      miss    <= 1'b1;
    end else if (strobe.loadOut) begin
      dataOut <= wordStore[rdPtr];
      miss    <= !lookupHit;
    end
  end
endmodule

// File: rtl/lineCache.sv
`timescale 1ns/1ps
module lineCache
  import lineCachePkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              readEn,
  input  logic              wrEn,
  input  logic              burstEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              miss
);
  cacheStrobeT      strobe;
  logic [OFF_W-1:0] wordSel;
  logic             lookupHit;

  lineCacheCtrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst(rst), .burstEn(burstEn), .wrEn(wrEn), .readEn(readEn),
    .lookupHit(lookupHit), .strobe(strobe), .wordSel(wordSel)
  );

  lineCacheData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst(rst), .addr(addr), .dataIn(dataIn), .strobe(strobe),
    .wordSel(wordSel), .lookupHit(lookupHit), .dataOut(dataOut), .miss(miss)
  );
endmodule

// File: rtl/lineCacheChecker.sv
`timescale 1ns/1ps
module lineCacheChecker
  import lineCachePkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              burstEn,
  input logic              wrEn,
  input logic              readEn,
  input logic              miss,
  input logic [DATA_W-1:0] dataOut,
  input cacheStrobeT       strobe,
  input logic [OFF_W-1:0]  wordSel,
  input logic              lookupHit
);
  localparam logic [OFF_W-1:0] ONE_WORD = 1;

  logic             prevBurst;
  logic [OFF_W-1:0] prevSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevBurst <= 1'b0;
      prevSel   <= '0;
    end else begin
      prevBurst <= burstEn;
      prevSel   <= wordSel;
    end
  end

  assert_reset_miss_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> miss);

  assert_load_on_read_R2: assert property (@(posedge clk) disable iff (rst)
    (readEn && !wrEn && !burstEn) |-> strobe.loadOut);

  assert_hold_outputs_R2: assert property (@(posedge clk) disable iff (rst)
    !(readEn && !wrEn && !burstEn) |=> ($stable(dataOut) && $stable(miss)));

  assert_fill_start_R6: assert property (@(posedge clk) disable iff (rst)
    (burstEn && !prevBurst) |-> (wordSel == '0));

  assert_fill_step_R4: assert property (@(posedge clk) disable iff (rst)
    (burstEn && prevBurst) |-> (wordSel == prevSel + ONE_WORD));

  assert_valid_on_last_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.markValid |-> (burstEn && wordSel == '1));

  assert_burst_priority_R8: assert property (@(posedge clk) disable iff (rst)
    burstEn |-> (strobe.fillWord && !strobe.storeWord && !strobe.loadOut));

  assert_store_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.storeWord |-> (wrEn && !burstEn && lookupHit));
endmodule

bind lineCache lineCacheChecker #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .burstEn(burstEn), .wrEn(wrEn), .readEn(readEn),
  .miss(miss), .dataOut(dataOut), .strobe(strobe), .wordSel(wordSel),
  .lookupHit(lookupHit)
);

// File: tb/lineCache_bench.sv
`timescale 1ns/1ps
module lineCache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = '0;
  logic [31:0] dataIn = '0;
  logic        readEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        burstEn = 1'b0;
  logic [31:0] dataOut;
  logic        miss;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  lineCache u_lineCache (
    .clk(clk), .rst(rst), .addr(addr), .dataIn(dataIn), .readEn(readEn),
    .wrEn(wrEn), .burstEn(burstEn), .dataOut(dataOut), .miss(miss)
  );

  function automatic logic [23:0] mkAddr(int tg, int ln, int w);
    return 24'((tg << 11) | (ln << 3) | w);
  endfunction

  function automatic logic [31:0] pat(int tg, int ln, int w);
    return 32'(tg * 32'h0100_0193) ^ 32'(ln << 12) ^ 32'(w * 32'h11) ^ 32'h5a5a_0000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic b, logic w, logic r, logic [23:0] a, logic [31:0] d);
    @(negedge clk);
    burstEn = b; wrEn = w; readEn = r; addr = a; dataIn = d;
  endtask

  task automatic stepSample();
    @(posedge clk);
    #1;
  endtask

  task automatic readWord(string req, int tg, int ln, int w, logic expMiss, logic [31:0] expData);
    drive(1'b0, 1'b0, 1'b1, mkAddr(tg, ln, w), 32'h0);
    stepSample();
    check({req, " miss"}, 32'(miss), 32'(expMiss));
    if (!expMiss) check({req, " data"}, dataOut, expData);
  endtask

  task automatic fillLine(int tg, int ln);
    for (int w = 0; w < 8; w++)
      drive(1'b1, 1'b0, 1'b0, mkAddr(tg, ln, w ^ 3), pat(tg, ln, w));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] heldData;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R3: reset values
    check("R3 reset miss", 32'(miss), 32'd1);
    check("R3 reset data", dataOut, 32'h0);
    readWord("R3 first read", 5, 0, 0, 1'b1, 32'h0);
    readWord("R3 first read", 5, 77, 4, 1'b1, 32'h0);
    readWord("R3 first read", 0, 255, 7, 1'b1, 32'h0);

    // R6: one held burst across lines 0..127, counter wraps per line
    for (int ln = 0; ln < 128; ln++) fillLine(5, ln);
    // R4: separate bursts with gaps for lines 128..255
    for (int ln = 128; ln < 256; ln++) begin
      fillLine(5, ln);
      drive(1'b0, 1'b0, 1'b0, 24'h0, 32'h0);
    end

    // R1 R4 R6 R9: full read-back sweep
    for (int ln = 0; ln < 256; ln++)
      for (int w = 0; w < 8; w++)
        readWord(ln < 128 ? "R6 sweep" : "R4 sweep", 5, ln, w, 1'b0, pat(5, ln, w));

    // R2: outputs hold through idle cycles
    readWord("R2 load", 5, 9, 4, 1'b0, pat(5, 9, 4));
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 1'b0, 1'b0, mkAddr(5, 200, k), 32'hdead_beef);
      stepSample();
      check("R2 hold data", dataOut, pat(5, 9, 4));
      check("R2 hold miss", 32'(miss), 32'd0);
    end
    // R2: back-to-back identical reads
    readWord("R2 repeat", 5, 33, 6, 1'b0, pat(5, 33, 6));
    readWord("R2 repeat", 5, 33, 6, 1'b0, pat(5, 33, 6));

    // R1: same index, other tag aliases and misses
    readWord("R1 alias", 6, 9, 4, 1'b1, 32'h0);
    readWord("R1 alias", 5 + 4096, 9, 4, 1'b1, 32'h0);
    readWord("R1 alias", 5, 9, 4, 1'b0, pat(5, 9, 4));

    // R7: store hit updates only the addressed word
    drive(1'b0, 1'b1, 1'b0, mkAddr(5, 10, 2), 32'h1234_5678);
    readWord("R7 store hit", 5, 10, 2, 1'b0, 32'h1234_5678);
    readWord("R7 neighbour", 5, 10, 1, 1'b0, pat(5, 10, 1));
    readWord("R7 neighbour", 5, 10, 3, 1'b0, pat(5, 10, 3));
    // R7: store with wrong tag ignored
    drive(1'b0, 1'b1, 1'b0, mkAddr(9, 11, 3), 32'hbad0_0001);
    readWord("R7 wrong tag", 5, 11, 3, 1'b0, pat(5, 11, 3));
    readWord("R7 wrong tag", 9, 11, 3, 1'b1, 32'h0);

    // R8: store and read together: store wins, outputs hold
    heldData = dataOut;
    drive(1'b0, 1'b1, 1'b1, mkAddr(5, 12, 0), 32'hcafe_0012);
    stepSample();
    check("R8 store over read miss", 32'(miss), 32'd1);
    check("R8 store over read data", dataOut, heldData);
    readWord("R8 store landed", 5, 12, 0, 1'b0, 32'hcafe_0012);

    // R8: burst with store and read high: fill order wins, offset ignored
    for (int w = 0; w < 8; w++)
      drive(1'b1, 1'b1, 1'b1, mkAddr(8, 20, 5), pat(8, 20, w));
    drive(1'b0, 1'b0, 1'b0, 24'h0, 32'h0);
    for (int w = 0; w < 8; w++)
      readWord("R8 burst priority", 8, 20, w, 1'b0, pat(8, 20, w));

    // R5: partial fill leaves line invalid under old and new tag
    for (int w = 0; w < 3; w++)
      drive(1'b1, 1'b0, 1'b0, mkAddr(7, 30, w), pat(7, 30, w));
    readWord("R5 partial new tag", 7, 30, 0, 1'b1, 32'h0);
    readWord("R5 partial old tag", 5, 30, 0, 1'b1, 32'h0);
    // R7: store to invalid line ignored, line stays invalid
    drive(1'b0, 1'b1, 1'b0, mkAddr(7, 30, 1), 32'hbad0_0030);
    readWord("R7 invalid line", 7, 30, 1, 1'b1, 32'h0);
    // R5: seven words is still not enough
    for (int w = 0; w < 7; w++)
      drive(1'b1, 1'b0, 1'b0, mkAddr(7, 30, w), pat(7, 30, w));
    readWord("R5 seven words", 7, 30, 6, 1'b1, 32'h0);

    // R6: restart after dropped burst, then full fill
    fillLine(7, 30);
    drive(1'b0, 1'b0, 1'b0, 24'h0, 32'h0);
    for (int w = 0; w < 8; w++)
      readWord("R6 restart", 7, 30, w, 1'b0, pat(7, 30, w));
    // R9: refill replaces earlier store
    fillLine(5, 10);
    readWord("R9 refill", 5, 10, 2, 1'b0, pat(5, 10, 2));

    finishRun();
  end
endmodule